// File: doc/BRIEF.md
# Indexed Configuration Space Controller

This block gives a host a byte-wide configuration register space through only two port locations. Offset 0 is the index port: a write there selects which configuration register is targeted next. Offset 1 is the data port: reads and writes there reach the register named by the current index. The index stays in place after each data access, so a register can be polled without re-selecting it.

The space holds a handful of global registers: a fixed chip identifier, a fixed revision and a device selector. It also holds a window of per-device registers. The device selector chooses which logical device's bank the window currently maps. Each bank holds an enable bit, a 16-bit I/O base address and a parameterised number of device-specific bytes. Each device owns a 16-byte I/O window at that base. The block drives every device's enable bit and base address straight to the rest of the chip, so the decoders for those windows can use them.

Index values are fixed because host software depends on them. The selector is at 0x07, the identifier at 0x20, the revision at 0x27, the enable register at 0x30, the base high byte at 0x60, the base low byte at 0x61, and device-specific bytes start at 0xF0.

Top module: `cfg_space_ctrl`

## Requirements
- R1: A write with `host_addr`=0 loads the index from `host_wdata`; a data access with `host_addr`=1 targets the register at that index; a read with `host_addr`=0 returns the index.
- R2: The index changes only on an index-port write, so consecutive data reads return the same register.
- R3: Index 0x20 reads as `ID_VALUE` (default 0xE9); writes to it have no effect.
- R4: Index 0x27 reads as `REV_VALUE` (default 0x03); writes to it have no effect.
- R5: Index 0x07 is the read/write device selector; a written value of `NUM_DEV` (default 15) or more is ignored and the previous selection is kept.
- R6: Index 0x30 holds the selected device's enable in bit 0; the other bits read as 0; the value drives `dev_active[n]` for device n.
- R7: Index 0x60 holds bits 15:8 and index 0x61 holds bits 7:0 of the selected device's base, driven on `dev_base[16n+15:16n]`.
- R8: A data write to a banked register changes only the currently selected device.
- R9: Indices 0xF0 up to 0xF0+`NUM_SPEC`-1 (default 2) are full-byte, banked, device-specific read/write registers.
- R10: Every other index reads as 0x00, and writes to it change no register or output.
- R11: Reset clears the index, the selector, every enable, every base, every device-specific byte and `host_rdata`.
- R12: With the default registered read port, `host_rdata` updates on the clock edge that samples `host_rd` and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_addr | input | 1 | 0 selects the index port, 1 the data port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data |
| dev_active | output | NUM_DEV | Enable bit of each logical device |
| dev_base | output | 16*NUM_DEV | I/O base of each device, device n at bits 16n+15:16n |

## Verification
On every cycle the assertions check several properties. The selector never holds an out-of-range device. The index moves only on an index write. An enable or base output changes only after a data write to its own index, and then for a single device. Writes to the identifier or revision leave all outputs still. The read port holds its value between strobes, and the identifier reads back as its constant. The stored contents of each bank can only be shown by the bench's scenarios. These sweep every device and write distinct computed values. They read the values back through the data port after the selector has moved, sweep every unimplemented index, and apply a reset in mid-run.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

   localparam logic [7:0] IDX_SELECT  = 8'h07;
   localparam logic [7:0] IDX_CHIPID  = 8'h20;
   localparam logic [7:0] IDX_REVISN  = 8'h27;
   localparam logic [7:0] IDX_ENABLE  = 8'h30;
   localparam logic [7:0] IDX_BASE_HI = 8'h60;
   localparam logic [7:0] IDX_BASE_LO = 8'h61;
   localparam logic [7:0] IDX_SPEC0   = 8'hF0;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_SELECT,
      RK_CHIPID,
      RK_REVISN,
      RK_ENABLE,
      RK_BASE_HI,
      RK_BASE_LO,
      RK_SPEC
   } reg_kind_e;

   // Map an index to the register class it reaches.
   function automatic reg_kind_e decode_idx(input logic [7:0] idx,
                                            input int unsigned nspec);
      reg_kind_e k;
      k = RK_NONE;
      if (idx == IDX_SELECT)       k = RK_SELECT;
      else if (idx == IDX_CHIPID)  k = RK_CHIPID;
      else if (idx == IDX_REVISN)  k = RK_REVISN;
      else if (idx == IDX_ENABLE)  k = RK_ENABLE;
      else if (idx == IDX_BASE_HI) k = RK_BASE_HI;
      else if (idx == IDX_BASE_LO) k = RK_BASE_LO;
      else if ((int'(idx) >= int'(IDX_SPEC0)) &&
               (int'(idx) < int'(IDX_SPEC0) + int'(nspec)))
         k = RK_SPEC;
      return k;
   endfunction

endpackage

// File: rtl/cfg_index_reg.sv
module cfg_index_reg #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] din,
   output logic [IDX_W-1:0] idx
);

   if (IDX_W < 1) begin : g_bad_w
      $error("cfg_index_reg: IDX_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx <= '0;
      else if (load) idx <= din;
   end

endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
   import cfg_space_pkg::*;
#(
   parameter int         NUM_DEV   = 15,
   parameter logic [7:0] ID_VALUE  = 8'hE9,
   parameter logic [7:0] REV_VALUE = 8'h03,
   localparam int        SEL_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  reg_kind_e        kind,
   input  logic [7:0]       wdata,
   output logic [SEL_W-1:0] sel_dev,
   output logic [7:0]       rd_val
);

   if (NUM_DEV < 1 || NUM_DEV > 256) begin : g_bad_ndev
      $error("cfg_global_regs: NUM_DEV must lie in 1..256");
   end

   logic sel_ok;
   assign sel_ok = (int'(wdata) < NUM_DEV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_dev <= '0;
      else if (wr_en && kind == RK_SELECT && sel_ok)
         sel_dev <= SEL_W'(wdata);
   end

   always_comb begin
      unique case (kind)
         RK_SELECT: rd_val = 8'(sel_dev);
         RK_CHIPID: rd_val = ID_VALUE;
         RK_REVISN: rd_val = REV_VALUE;
         default:   rd_val = 8'h00;
      endcase
   end

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
   import cfg_space_pkg::*;
#(
   parameter int  NUM_SPEC = 2,
   localparam int SPEC_W   = (NUM_SPEC > 1) ? $clog2(NUM_SPEC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr_en,
   input  reg_kind_e         kind,
   input  logic [SPEC_W-1:0] spec_sel,
   input  logic [7:0]        wdata,
   output logic              active,
   output logic [15:0]       base,
   output logic [7:0]        rd_val
);

   if (NUM_SPEC < 1 || NUM_SPEC > 16) begin : g_bad_nspec
      $error("cfg_dev_bank: NUM_SPEC must lie in 1..16");
   end

   logic [NUM_SPEC-1:0][7:0] spec_q;
   logic                     bank_wr;
   logic [7:0]               spec_rd;

   assign bank_wr = wr_en & sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         base   <= '0;
      end else if (bank_wr) begin
         if (kind == RK_ENABLE)  active     <= wdata[0];
         if (kind == RK_BASE_HI) base[15:8] <= wdata;
         if (kind == RK_BASE_LO) base[7:0]  <= wdata;
      end
   end

   for (genvar k = 0; k < NUM_SPEC; k++) begin : g_spec
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            spec_q[k] <= '0;
         else if (bank_wr && kind == RK_SPEC && spec_sel == SPEC_W'(k))
            spec_q[k] <= wdata;
      end
   end

   always_comb begin
      spec_rd = 8'h00;
      for (int k = 0; k < NUM_SPEC; k++)
         if (spec_sel == SPEC_W'(k)) spec_rd = spec_q[k];
   end

   always_comb begin
      rd_val = 8'h00;
      if (sel) begin
         unique case (kind)
            RK_ENABLE:  rd_val = {7'b0, active};
            RK_BASE_HI: rd_val = base[15:8];
            RK_BASE_LO: rd_val = base[7:0];
            RK_SPEC:    rd_val = spec_rd;
            default:    rd_val = 8'h00;
         endcase
      end
   end

endmodule

// File: rtl/cfg_space_ctrl.sv
module cfg_space_ctrl
   import cfg_space_pkg::*;
#(
   parameter int         NUM_DEV         = 15,
   parameter int         NUM_SPEC        = 2,
   parameter logic [7:0] ID_VALUE        = 8'hE9,
   parameter logic [7:0] REV_VALUE       = 8'h03,
   parameter bit         READ_REGISTERED = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_wr,
   input  logic                  host_rd,
   input  logic                  host_addr,
   input  logic [7:0]            host_wdata,
   output logic [7:0]            host_rdata,
   output logic [NUM_DEV-1:0]    dev_active,
   output logic [16*NUM_DEV-1:0] dev_base
);

   localparam int SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
   localparam int SPEC_W = (NUM_SPEC > 1) ? $clog2(NUM_SPEC) : 1;

   if (NUM_DEV < 1 || NUM_DEV > 256) begin : g_bad_ndev
      $error("cfg_space_ctrl: NUM_DEV must lie in 1..256");
   end
   if (NUM_SPEC < 1 || NUM_SPEC > 16) begin : g_bad_nspec
      $error("cfg_space_ctrl: NUM_SPEC must lie in 1..16");
   end

   logic              idx_load;
   logic              data_wr;
   logic [7:0]        idx_q;
   logic [SEL_W-1:0]  sel_q;
   reg_kind_e         kind;
   logic [SPEC_W-1:0] spec_sel;
   logic [7:0]        glob_rd;
   logic [NUM_DEV-1:0][7:0] bank_rd;
   logic [7:0]        bank_or;
   logic [7:0]        rd_mux;

   assign idx_load = host_wr & ~host_addr;
   assign data_wr  = host_wr &  host_addr;
   assign kind     = decode_idx(idx_q, NUM_SPEC);
   assign spec_sel = SPEC_W'(idx_q - IDX_SPEC0);

   cfg_index_reg #(.IDX_W(8)) idx_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (idx_load),
      .din   (host_wdata),
      .idx   (idx_q)
   );

   cfg_global_regs #(
      .NUM_DEV   (NUM_DEV),
      .ID_VALUE  (ID_VALUE),
      .REV_VALUE (REV_VALUE)
   ) glob_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (data_wr),
      .kind    (kind),
      .wdata   (host_wdata),
      .sel_dev (sel_q),
      .rd_val  (glob_rd)
   );

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
      cfg_dev_bank #(.NUM_SPEC(NUM_SPEC)) bank_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel      (sel_q == SEL_W'(d)),
         .wr_en    (data_wr),
         .kind     (kind),
         .spec_sel (spec_sel),
         .wdata    (host_wdata),
         .active   (dev_active[d]),
         .base     (dev_base[16*d +: 16]),
         .rd_val   (bank_rd[d])
      );
   end

   // Only the selected bank drives a non-zero value.
   always_comb begin
      bank_or = 8'h00;
      for (int d = 0; d < NUM_DEV; d++) bank_or = bank_or | bank_rd[d];
   end

   assign rd_mux = host_addr ? (glob_rd | bank_or) : idx_q;

   if (READ_REGISTERED) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       host_rdata <= 8'h00;
         else if (host_rd) host_rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign host_rdata = rd_mux;
   end

endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
   parameter int         NUM_DEV         = 15,
   parameter logic [7:0] ID_VALUE        = 8'hE9,
   parameter bit         READ_REGISTERED = 1'b1,
   parameter int         SEL_W           = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  host_wr,
   input logic                  host_rd,
   input logic                  host_addr,
   input logic [7:0]            host_rdata,
   input logic [NUM_DEV-1:0]    dev_active,
   input logic [16*NUM_DEV-1:0] dev_base,
   input logic [7:0]            cur_idx,
   input logic [SEL_W-1:0]      cur_sel
);

   p_sel_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cur_sel) < NUM_DEV);

   p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && !host_addr) |=> $stable(cur_idx));

   p_enable_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dev_active) |-> $past(host_wr && host_addr && cur_idx == 8'h30));

   p_base_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dev_base) |->
         $past(host_wr && host_addr && (cur_idx == 8'h60 || cur_idx == 8'h61)));

   p_one_dev_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dev_active ^ $past(dev_active)) <= 1);

   p_ro_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_addr && (cur_idx == 8'h20 || cur_idx == 8'h27)
      |=> $stable(dev_active) && $stable(dev_base));

   if (READ_REGISTERED) begin : g_rd_props
      p_chipid_r3: assert property (@(posedge clk) disable iff (!rst_n)
         host_rd && host_addr && !host_wr && cur_idx == 8'h20
         |=> host_rdata == ID_VALUE);

      p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
         !host_rd |=> $stable(host_rdata));
   end

endmodule

bind cfg_space_ctrl cfg_space_chk #(
   .NUM_DEV         (NUM_DEV),
   .ID_VALUE        (ID_VALUE),
   .READ_REGISTERED (READ_REGISTERED),
   .SEL_W           (SEL_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .host_addr  (host_addr),
   .host_rdata (host_rdata),
   .dev_active (dev_active),
   .dev_base   (dev_base),
   .cur_idx    (idx_q),
   .cur_sel    (sel_q)
);

// File: tb/cfg_space_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfg_space_ctrl_tb_top;

   localparam int NDEV  = 15;
   localparam int NSPEC = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_wr = 1'b0;
   logic              host_rd = 1'b0;
   logic              host_addr = 1'b0;
   logic [7:0]        host_wdata = 8'h00;
   logic [7:0]        host_rdata;
   logic [NDEV-1:0]   dev_active;
   logic [16*NDEV-1:0] dev_base;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic        exp_act  [NDEV];
   logic [15:0] exp_base [NDEV];
   logic [7:0]  exp_spec [NDEV][NSPEC];

   always #10 clk = ~clk;

   cfg_space_ctrl dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .dev_active (dev_active),
      .dev_base   (dev_base)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      @(negedge clk);
      host_rd = 1'b0;
      v = host_rdata;
   endtask

   task automatic rd_reg(input logic [7:0] idx, output logic [7:0] v);
      wr(1'b0, idx);
      rd(1'b1, v);
   endtask

   task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
      wr(1'b0, idx);
      wr(1'b1, d);
   endtask

   function automatic bit implemented(input int i);
      return (i == 8'h07 || i == 8'h20 || i == 8'h27 || i == 8'h30 ||
              i == 8'h60 || i == 8'h61 || (i >= 8'hF0 && i < 8'hF0 + NSPEC));
   endfunction

   task automatic check_outputs(input string req);
      for (int d = 0; d < NDEV; d++) begin
         check(req, 32'(dev_active[d]), 32'(exp_act[d]));
         check(req, 32'(dev_base[16*d +: 16]), 32'(exp_base[d]));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, v2;
      for (int d = 0; d < NDEV; d++) begin
         exp_act[d] = 1'b0; exp_base[d] = 16'h0;
         for (int k = 0; k < NSPEC; k++) exp_spec[d][k] = 8'h00;
      end
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 rdata", 32'(host_rdata), 32'h0);
      check("R11 active", 32'(dev_active), 32'h0);
      check("R11 base", 32'(dev_base == '0), 32'h1);
      rst_n = 1'b1;
      rd(1'b0, v);  check("R11 index", 32'(v), 32'h0);
      rd(1'b1, v);  check("R11 select via index 0", 32'(v), 32'h0);

      // R3 / R4 read-only
      rd_reg(8'h20, v); check("R3 id", 32'(v), 32'hE9);
      wr(1'b1, 8'h55); rd(1'b1, v); check("R3 id after write", 32'(v), 32'hE9);
      rd_reg(8'h27, v); check("R4 rev", 32'(v), 32'h03);
      wr(1'b1, 8'hAA); rd(1'b1, v); check("R4 rev after write", 32'(v), 32'h03);
      check_outputs("R3 outputs after ro write");

      // R6 R7 R9: program every device
      for (int d = 0; d < NDEV; d++) begin
         wr_reg(8'h07, 8'(d));
         wr_reg(8'h30, {4'(d), 4'(d)});
         exp_act[d] = d[0];
         wr_reg(8'h60, 8'(8'h10 + d));
         wr_reg(8'h61, 8'(d * 16));
         exp_base[d] = {8'(8'h10 + d), 8'(d * 16)};
         for (int k = 0; k < NSPEC; k++) begin
            wr_reg(8'(8'hF0 + k), 8'(8'h40 + d * 8 + k));
            exp_spec[d][k] = 8'(8'h40 + d * 8 + k);
         end
         // R8 outputs of all devices match after each device's programming
         check_outputs("R8 banked write");
      end

      // read back in reverse order
      for (int d = NDEV - 1; d >= 0; d--) begin
         wr_reg(8'h07, 8'(d));
         rd(1'b1, v);      check("R5 select readback", 32'(v), 32'(d));
         rd_reg(8'h30, v); check("R6 enable readback", 32'(v), 32'(exp_act[d]));
         rd_reg(8'h60, v); check("R7 base hi readback", 32'(v), 32'(exp_base[d][15:8]));
         rd_reg(8'h61, v); check("R7 base lo readback", 32'(v), 32'(exp_base[d][7:0]));
         for (int k = 0; k < NSPEC; k++) begin
            rd_reg(8'(8'hF0 + k), v);
            check("R9 spec readback", 32'(v), 32'(exp_spec[d][k]));
         end
      end

      // R5 out-of-range select ignored
      wr_reg(8'h07, 8'd5);
      wr(1'b1, 8'd15); rd(1'b1, v); check("R5 select 15 ignored", 32'(v), 32'd5);
      wr(1'b1, 8'hFF); rd(1'b1, v); check("R5 select FF ignored", 32'(v), 32'd5);

      // R2 / R1 index persistence
      wr(1'b0, 8'h61);
      for (int n = 0; n < 3; n++) begin
         rd(1'b1, v); check("R2 repeated read", 32'(v), 32'(exp_base[5][7:0]));
      end
      rd(1'b0, v); check("R1 index readback", 32'(v), 32'h61);

      // R12 hold without strobe
      repeat (4) @(negedge clk);
      check("R12 rdata held", 32'(host_rdata), 32'h61);

      // R10 unimplemented indices
      for (int i = 0; i < 256; i++) begin
         if (!implemented(i)) begin
            wr_reg(8'(i), 8'hA5);
            rd(1'b1, v);
            if (v !== 8'h00) check("R10 unimplemented read", 32'(v), 32'h0);
            else total++;
         end
      end
      check_outputs("R10 outputs after unimplemented writes");
      rd_reg(8'h07, v2); check("R10 select kept", 32'(v2), 32'd5);

      // R11 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R11 active after reset", 32'(dev_active), 32'h0);
      check("R11 base after reset", 32'(dev_base == '0), 32'h1);
      check("R11 rdata after reset", 32'(host_rdata), 32'h0);
      rst_n = 1'b1;
      rd(1'b0, v); check("R11 index after reset", 32'(v), 32'h0);
      rd_reg(8'h07, v); check("R11 select after reset", 32'(v), 32'h0);
      rd_reg(8'hF0, v); check("R11 spec after reset", 32'(v), 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule